// File: doc/BRIEF.md
# Cascaded Programmable Clock Divider

The block turns one fast reference clock into two slower clocks in a chain. The first stage divides the reference by a power of two between 1 and 64, selected by a 3-bit code. The second stage counts periods of the first stage's output and divides them by an odd ratio of 1, 3, 5 or 7, selected by a 2-bit code. Both stages also give out a one-cycle enable pulse in the reference domain, so logic clocked by the reference can run at either divided rate without crossing a clock boundary.

The codes come straight from register outputs and may be rewritten at any moment. A new pair of codes is checked and taken up only at the end of a full period of the second stage, which is also a period boundary of the first stage. So no output pulse is ever cut short. A code pair whose combined ratio is above 64 is refused and flagged while it stays on the inputs. The reserved first-stage code is refused and recorded in a flag that stays set until reset. In both cases the ratios in use do not change.

Top module: `clk_chain_div`

## Requirements
- R1: After reset both codes in use are zero. Both enable pulses are then high on every reference cycle, and both error outputs are low.
- R2: With first-stage code c (0 to 6), `pre_tick` is high for exactly one reference cycle in every 2^c cycles.
- R3: With second-stage code k, `odd_tick` is high once in every (2k+1)·2^c reference cycles. It coincides with a `pre_tick`, and each of its periods contains exactly 2k+1 `pre_tick` pulses.
- R4: When the first-stage ratio is 2 or more, `clk_pre` is high for exactly half the reference cycles of each of its periods. When the combined ratio is even, `clk_odd` is high for exactly half of its period. When the combined ratio is odd and above 1, the high and low phases of `clk_odd` differ by half a reference cycle at most.
- R5: First-stage code 7 is reserved. It never becomes active, and the codes already in use stay in effect. `reserved_err` goes high one cycle after the code appears and stays high until reset, even after legal codes are written.
- R6: If (2k+1)·2^c exceeds 64 for a non-reserved code pair, the pair is not applied. `config_error` is high from the cycle after the pair appears until one cycle after a legal pair replaces it.
- R7: Codes written in the middle of an output period do not change that period. A legal new pair takes effect on the first reference edge after the cycle in which `odd_tick` is high, and both counters restart there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_code | input | 3 | First-stage code: 0..6 gives divide by 2^code, 7 is reserved |
| odd_code | input | 2 | Second-stage code: divide by 2·code+1 |
| clk_pre | output | 1 | First-stage divided clock |
| pre_tick | output | 1 | One-cycle enable at the first-stage rate |
| clk_odd | output | 1 | Second-stage divided clock |
| odd_tick | output | 1 | One-cycle enable at the second-stage rate, marks the period boundary |
| reserved_err | output | 1 | Sticky flag: the reserved first-stage code was seen |
| config_error | output | 1 | The code pair now on the inputs exceeds the ratio cap |

## Verification
The hardest case to reach from the ports is a code change that lands in the middle of a period. The design must finish that period at the old length, and then switch exactly at the boundary. To get there, the stimulus waits for an `odd_tick` and queues one more period at the old ratio. A cycle later it writes the new codes, and only after the next `odd_tick` does it queue periods at the new ratio. The monitor measures each period between `odd_tick` pulses, counting `pre_tick` pulses and high samples along the way. A switch made early or late therefore shows up as a period of the wrong length.

// File: rtl/clk_chain_div.sv
module clk_chain_div #(
  parameter int MAX_RATIO = 64
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic [2:0] pre_code,
  input  logic [1:0] odd_code,
  output logic       clk_pre,
  output logic       pre_tick,
  output logic       clk_odd,
  output logic       odd_tick,
  output logic       reserved_err,
  output logic       config_error
);

  localparam logic [9:0] CAP = 10'(MAX_RATIO);

  logic [2:0] act_pre, nx_pre;
  logic [1:0] act_odd, nx_odd;
  logic [6:0] pre_cnt, pre_cnt_nx, n_act, n_nx;
  logic [2:0] odd_cnt, odd_cnt_nx, m_act;
  logic [9:0] prod_in, p_nx, pos_nx, thr;
  logic       in_res, in_big, legal, apply;
  logic       pre_q, odd_q, odd_qn, n_one_r, p_one_r, p_odd_r;

  // code check against the joint cap
  assign in_res  = (pre_code == 3'b111);
  assign prod_in = {7'd0, odd_code, 1'b1} << pre_code;
  assign in_big  = !in_res && (prod_in > CAP);
  assign legal   = !in_res && !in_big;

  // the odd stage counts first-stage ticks
  assign n_act    = 7'd1 << act_pre;
  assign m_act    = {act_odd, 1'b1};
  assign pre_tick = (pre_cnt == n_act - 7'd1);
  assign odd_tick = pre_tick && (odd_cnt == m_act - 3'd1);
  assign apply    = odd_tick && legal;

  assign nx_pre     = apply ? pre_code : act_pre;
  assign nx_odd     = apply ? odd_code : act_odd;
  assign n_nx       = 7'd1 << nx_pre;
  assign p_nx       = {7'd0, nx_odd, 1'b1} << nx_pre;
  assign pre_cnt_nx = pre_tick ? 7'd0 : pre_cnt + 7'd1;
  assign odd_cnt_nx = odd_tick ? 3'd0 : (pre_tick ? odd_cnt + 3'd1 : odd_cnt);
  assign pos_nx     = ({7'd0, odd_cnt_nx} << nx_pre) + {3'd0, pre_cnt_nx};
  assign thr        = (p_nx + 10'd1) >> 1;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      act_pre      <= '0;
      act_odd      <= '0;
      pre_cnt      <= '0;
      odd_cnt      <= '0;
      pre_q        <= 1'b0;
      odd_q        <= 1'b0;
      n_one_r      <= 1'b1;
      p_one_r      <= 1'b1;
      p_odd_r      <= 1'b1;
      reserved_err <= 1'b0;
      config_error <= 1'b0;
    end else begin
      act_pre      <= nx_pre;
      act_odd      <= nx_odd;
      pre_cnt      <= pre_cnt_nx;
      odd_cnt      <= odd_cnt_nx;
      pre_q        <= pre_cnt_nx < (n_nx >> 1);
      odd_q        <= pos_nx < thr;
      n_one_r      <= (nx_pre == 3'd0);
      p_one_r      <= (p_nx == 10'd1);
      p_odd_r      <= p_nx[0];
      reserved_err <= reserved_err | in_res;
      config_error <= in_big;
    end
  end

  // falling-edge copy trims the odd-ratio high phase by half a cycle
  always_ff @(negedge clk_ref or negedge rst_n) begin
    if (!rst_n) odd_qn <= 1'b0;
    else        odd_qn <= odd_q;
  end

  assign clk_pre = n_one_r ? clk_ref : pre_q;
  assign clk_odd = p_one_r ? clk_ref : (p_odd_r ? (odd_q & odd_qn) : odd_q);

  a_r2_pre_cnt_range: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pre_cnt < n_act);
  a_r3_odd_cnt_range: assert property (@(posedge clk_ref) disable iff (!rst_n)
    odd_cnt < m_act);
  a_r3_odd_on_pre: assert property (@(posedge clk_ref) disable iff (!rst_n)
    odd_tick |-> pre_tick);
  a_r5_reserved_never_active: assert property (@(posedge clk_ref) disable iff (!rst_n)
    act_pre != 3'b111);
  a_r5_reserved_sticky: assert property (@(posedge clk_ref) disable iff (!rst_n)
    reserved_err |=> reserved_err);
  a_r6_refused_pair_held: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (odd_tick && in_big) |=> ($stable(act_pre) && $stable(act_odd)));
  a_r7_mid_period_hold: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !odd_tick |=> ($stable(act_pre) && $stable(act_odd)));
  a_r7_restart_at_boundary: assert property (@(posedge clk_ref) disable iff (!rst_n)
    odd_tick |=> (pre_cnt == 7'd0 && odd_cnt == 3'd0));

endmodule

// File: tb/clk_chain_div_tb.sv
`timescale 1ns/1ps
module clk_chain_div_tb;
  logic clk_ref = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] pre_code = '0;
  logic [1:0] odd_code = '0;
  logic clk_pre, pre_tick, clk_odd, odd_tick, reserved_err, config_error;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  int cur_n = 1, cur_m = 1;

  typedef struct packed { int n; int m; } exp_t;
  exp_t q[$];

  always #2 clk_ref = ~clk_ref;

  clk_chain_div u_dut (
    .clk_ref(clk_ref), .rst_n(rst_n), .pre_code(pre_code), .odd_code(odd_code),
    .clk_pre(clk_pre), .pre_tick(pre_tick), .clk_odd(clk_odd), .odd_tick(odd_tick),
    .reserved_err(reserved_err), .config_error(config_error)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_ref);
    #0.5;
  endtask

  task automatic drain();
    while (q.size() != 0) tick();
  endtask

  // one old-ratio period around a mid-period write, then periods at the new ratio
  task automatic configure(input int pc, input int oc, input int en, input int em);
    drain();
    while (!odd_tick) tick();
    tick();
    q.push_back('{cur_n, cur_m});
    tick();
    pre_code = 3'(pc);
    odd_code = 2'(oc);
    while (!odd_tick) tick();
    tick();
    cur_n = en;
    cur_m = em;
    for (int i = 0; i < 2; i++) q.push_back('{en, em});
    drain();
  endtask

  // monitor: measures every odd_tick period and compares against the queue
  initial begin
    int cyc, pt, hp, ho, p;
    exp_t e;
    cyc = 0; pt = 0; hp = 0; ho = 0;
    wait (mon_on);
    forever begin
      @(posedge clk_ref);
      #1;
      cyc++;
      pt += int'(pre_tick);
      hp += int'(clk_pre);
      ho += int'(clk_odd);
      if (odd_tick) begin
        if (q.size() != 0) begin
          e = q.pop_front();
          p = e.n * e.m;
          check("R3/R7 odd period length", cyc, p);
          check("R2/R3 pre ticks per odd period", pt, e.m);
          if (e.n >= 2) begin
            check("R4 clk_pre high samples", hp, p / 2);
            check("R4 clk_odd high samples", ho, p / 2);
          end
        end
        cyc = 0; pt = 0; hp = 0; ho = 0;
      end
    end
  end

  // pre_tick spacing
  initial begin
    int gap;
    gap = 0;
    wait (mon_on);
    forever begin
      @(posedge clk_ref);
      #1;
      gap++;
      if (pre_tick) begin
        if (q.size() != 0 && cur_n == q[0].n) check("R2 pre_tick spacing", gap, cur_n);
        gap = 0;
      end
    end
  end

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_ref);
    #0.5;
    rst_n = 1'b1;
    tick();
    check("R1 pre_tick after reset", int'(pre_tick), 1);
    check("R1 odd_tick after reset", int'(odd_tick), 1);
    check("R1 reserved_err after reset", int'(reserved_err), 0);
    check("R1 config_error after reset", int'(config_error), 0);
    tick();
    check("R1 odd_tick stays high", int'(odd_tick), 1);
    mon_on = 1'b1;

    configure(1, 0, 2, 1);
    configure(0, 1, 1, 3);
    configure(2, 2, 4, 5);
    configure(3, 3, 8, 7);
    configure(6, 0, 64, 1);
    configure(4, 1, 16, 3);
    configure(5, 0, 32, 1);

    configure(5, 1, 32, 1);
    check("R6 config_error on 96", int'(config_error), 1);
    check("R6 reserved_err untouched", int'(reserved_err), 0);

    configure(7, 0, 32, 1);
    check("R5 reserved_err set", int'(reserved_err), 1);
    check("R5 config_error low for reserved", int'(config_error), 0);

    configure(1, 3, 2, 7);
    check("R6 config_error cleared", int'(config_error), 0);
    check("R5 reserved_err sticky", int'(reserved_err), 1);

    configure(0, 3, 1, 7);
    configure(0, 0, 1, 1);
    tick();
    check("R7 back to divide by 1", int'(odd_tick), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule